// File: doc/BRIEF.md
# Parameter Page Integrity Checker

This block watches the bytes of a flash device's parameter page as they come off the data bus and gives a verdict once the page is complete. Each byte offered with a valid strobe is counted. The leading bytes are compared against a fixed four-character ASCII signature. The first 254 bytes are folded into a 16-bit CRC, and the two bytes that follow are read as the expected check value.

A controller pulses `start` before it issues the page read. It then forwards each received byte with `byteValid`. The verdict is ready when `done` pulses. The two result flags stay readable until the next `start`, so firmware or a sequencer can sample them at leisure. Any bytes that arrive after the page has ended are dropped.

Top module: `param_page_crc_check`

## Requirements
- R1: The CRC uses generator polynomial 0x8005 over a 16-bit register. Bits enter most-significant first. Each step computes feedback = reg[15] XOR data bit, shifts the register left by one, and XORs in the polynomial when feedback is 1.
- R2: The register holds 0x4F4E before the first byte of a page is folded in.
- R3: Only accepted bytes 0 to 253 enter the CRC. A change to any single bit within them makes `crcOk` 0.
- R4: The check value is little-endian: byte 254 is its low byte and byte 255 its high byte. `crcOk` is 1 only when that value equals the computed CRC.
- R5: `sigOk` is 1 only when accepted bytes 0 to 3 are 0x4F, 0x4E, 0x46, 0x49 ('O','N','F','I'). `sigOk` does not depend on the CRC result.
- R6: `done` is high for exactly one cycle, in the cycle after byte 255 is accepted. `crcOk` and `sigOk` are valid in that same cycle. A cycle with `byteValid` low does not advance the byte count.
- R7: Bytes offered after byte 255 and before the next `start` have no effect: `done`, `crcOk` and `sigOk` do not change.
- R8: A `start` pulse restarts the page from byte 0, including in the middle of a page. In the cycle after `start`, `crcOk`, `sigOk` and `done` are all 0. A byte offered in the same cycle as `start` is not accepted.
- R9: After `done`, `crcOk` and `sigOk` keep their values until the next `start`.
- R10: After reset, `done`, `crcOk` and `sigOk` are 0. No byte is accepted until the first `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new page; clears the state |
| byteValid | input | 1 | `byteData` holds a page byte this cycle |
| byteData | input | 8 | Page byte |
| crcOk | output | 1 | Computed CRC matches the stored check value |
| sigOk | output | 1 | Leading four bytes match the signature |
| done | output | 1 | One-cycle pulse when the page is complete |

## Verification
Every result of this block comes from one register stage.

- `done`, `crcOk` and `sigOk` move in the cycle after the clock edge that takes byte 255.
- The clear that `start` causes appears in the cycle after the clock edge that samples `start`.

The bench drives inputs on falling edges and samples outputs on the next falling edge. That places each check exactly one rising edge after its stimulus. It then samples one edge later to confirm that `done` has fallen and that the flags have held.

// File: rtl/param_page_pkg.sv
package param_page_pkg;
  localparam int CRC_W = 16;

  typedef struct packed {
    logic clear;
    logic crcEn;
    logic sigEn;
    logic chkLo;
    logic chkHi;
  } pageStrobes_t;
endpackage

// File: rtl/page_ctrl.sv
module page_ctrl
  import param_page_pkg::*;
#(
  parameter int COVER_LEN = 254,
  parameter int SIG_LEN   = 4,
  localparam int CNT_W    = $clog2(COVER_LEN + 3),
  localparam int SIG_IDX_W = (SIG_LEN > 1) ? $clog2(SIG_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 byteValid,
  output pageStrobes_t         st,
  output logic [SIG_IDX_W-1:0] sigIdx,
  output logic                 done
);
  localparam logic [CNT_W-1:0] LO_IDX   = CNT_W'(COVER_LEN);
  localparam logic [CNT_W-1:0] HI_IDX   = CNT_W'(COVER_LEN + 1);
  localparam logic [CNT_W-1:0] SIG_END  = CNT_W'(SIG_LEN);
  localparam logic [CNT_W-1:0] COV_END  = CNT_W'(COVER_LEN);

  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             take;

  assign take   = byteValid && active && !start;
  assign sigIdx = cnt[SIG_IDX_W-1:0];

  always_comb begin
    st       = '0;
    st.clear = start;
    if (take) begin
      st.crcEn = (cnt < COV_END);
      st.sigEn = (cnt < SIG_END);
      st.chkLo = (cnt == LO_IDX);
      st.chkHi = (cnt == HI_IDX);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      cnt    <= '0;
      active <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= st.chkHi;
      if (take) begin
        cnt <= cnt + 1'b1;
        if (cnt == HI_IDX) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/page_datapath.sv
module page_datapath
  import param_page_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY     = 16'h8005,
  parameter logic [CRC_W-1:0] SEED     = 16'h4F4E,
  parameter int               SIG_LEN  = 4,
  parameter logic [8*SIG_LEN-1:0] SIGNATURE = 32'h4F4E_4649,
  localparam int SIG_IDX_W = (SIG_LEN > 1) ? $clog2(SIG_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pageStrobes_t         st,
  input  logic [SIG_IDX_W-1:0] sigIdx,
  input  logic [7:0]           byteData,
  output logic                 crcOk,
  output logic                 sigOk
);
  logic [CRC_W-1:0] crcReg;
  logic [7:0]       chkLoReg;
  logic             sigGood;
  logic [7:0]       expByte;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c,
                                               input logic [7:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      fb = r[CRC_W-1] ^ d[b];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  always_comb begin
    expByte = '0;
    for (int i = 0; i < SIG_LEN; i++) begin
      if (sigIdx == SIG_IDX_W'(i)) expByte = SIGNATURE[8*(SIG_LEN-1-i) +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg   <= SEED;
      chkLoReg <= '0;
      sigGood  <= 1'b0;
      crcOk    <= 1'b0;
      sigOk    <= 1'b0;
    end else if (st.clear) begin
      crcReg   <= SEED;
      chkLoReg <= '0;
      sigGood  <= 1'b1;
      crcOk    <= 1'b0;
      sigOk    <= 1'b0;
    end else begin
      if (st.crcEn) crcReg <= crcByte(crcReg, byteData);
      if (st.sigEn && (byteData != expByte)) sigGood <= 1'b0;
      if (st.chkLo) chkLoReg <= byteData;
      if (st.chkHi) begin
        crcOk <= (crcReg == {byteData, chkLoReg});
        sigOk <= sigGood;
      end
    end
  end
endmodule

// File: rtl/param_page_crc_check.sv
module param_page_crc_check
  import param_page_pkg::*;
#(
  parameter int               COVER_LEN = 254,
  parameter int               SIG_LEN   = 4,
  parameter logic [CRC_W-1:0] POLY      = 16'h8005,
  parameter logic [CRC_W-1:0] SEED      = 16'h4F4E,
  parameter logic [8*SIG_LEN-1:0] SIGNATURE = 32'h4F4E_4649,
  localparam int SIG_IDX_W = (SIG_LEN > 1) ? $clog2(SIG_LEN) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  output logic       crcOk,
  output logic       sigOk,
  output logic       done
);
  pageStrobes_t         st;
  logic [SIG_IDX_W-1:0] sigIdx;

  page_ctrl #(
    .COVER_LEN(COVER_LEN),
    .SIG_LEN  (SIG_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .byteValid(byteValid),
    .st       (st),
    .sigIdx   (sigIdx),
    .done     (done)
  );

  page_datapath #(
    .POLY     (POLY),
    .SEED     (SEED),
    .SIG_LEN  (SIG_LEN),
    .SIGNATURE(SIGNATURE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .sigIdx  (sigIdx),
    .byteData(byteData),
    .crcOk   (crcOk),
    .sigOk   (sigOk)
  );
endmodule

// File: rtl/param_page_checker.sv
module param_page_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic byteValid,
  input logic crcOk,
  input logic sigOk,
  input logic done
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_done_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(byteValid));

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!done && !crcOk && !sigOk));

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !byteValid) |=> ($stable(crcOk) && $stable(sigOk)));

  a_r7_no_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid) |=> !done);
endmodule

bind param_page_crc_check param_page_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .byteValid(byteValid),
  .crcOk    (crcOk),
  .sigOk    (sigOk),
  .done     (done)
);

// File: tb/param_page_crc_check_bench.sv
module param_page_crc_check_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       crcOk, sigOk, done;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;
  logic [7:0] page [256];

  always #2.5 clk = ~clk;

  param_page_crc_check u_param_page_crc_check (
    .clk(clk), .rstN(rstN), .start(start), .byteValid(byteValid),
    .byteData(byteData), .crcOk(crcOk), .sigOk(sigOk), .done(done)
  );

  function automatic logic [15:0] refCrc();
    logic [15:0] c;
    logic        fb;
    c = 16'h4F4E;
    for (int i = 0; i < 254; i++)
      for (int b = 7; b >= 0; b--) begin
        fb = c[15] ^ page[i][b];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h8005;
      end
    return c;
  endfunction

  task automatic check(input bit actual, input bit expected, input string req);
    testCnt++;
    if (actual !== expected) begin
      failCnt++;
      $display("FAIL %s actual=%0b expected=%0b", req, actual, expected);
    end
  endtask

  task automatic sealPage();
    logic [15:0] c;
    c = refCrc();
    page[254] = c[7:0];
    page[255] = c[15:8];
  endtask

  task automatic buildPage(input logic [7:0] salt);
    for (int i = 0; i < 256; i++) page[i] = 8'(i * 7) ^ salt;
    page[0] = 8'h4F; page[1] = 8'h4E; page[2] = 8'h46; page[3] = 8'h49;
    sealPage();
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Drives a page; returns on the negedge where done is due.
  task automatic sendPage(input int gap);
    pulseStart();
    for (int i = 0; i < 256; i++) begin
      if (gap > 0 && (i % gap) == gap - 1) begin
        byteValid = 1'b0;
        byteData  = 8'hA5;
        @(negedge clk);
      end
      byteValid = 1'b1;
      byteData  = page[i];
      @(negedge clk);
    end
    byteValid = 1'b0;
  endtask

  task automatic runPage(input int gap, input bit expCrc, input bit expSig, input string req);
    sendPage(gap);
    check(done, 1'b1, {req, " done"});
    check(crcOk, expCrc, {req, " crcOk"});
    check(sigOk, expSig, {req, " sigOk"});
    @(negedge clk);
    check(done, 1'b0, "R6 done one cycle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done, 1'b0, "R10 reset done");
    check(crcOk, 1'b0, "R10 reset crcOk");
    check(sigOk, 1'b0, "R10 reset sigOk");
    // R10: bytes before the first start are not accepted
    for (int i = 0; i < 300; i++) begin
      byteValid = 1'b1; byteData = 8'(i); @(negedge clk);
      if (done) check(done, 1'b0, "R10 no byte before start");
    end
    byteValid = 1'b0;

    // R1 R2 R3 R4 R5: good pages with several payloads
    buildPage(8'h00); runPage(0, 1'b1, 1'b1, "R1 R2 good page");
    buildPage(8'h5A); runPage(0, 1'b1, 1'b1, "R2 good page 2");
    buildPage(8'hFF); runPage(3, 1'b1, 1'b1, "R6 gapped good page");

    // R9: flags hold while idle
    repeat (20) @(negedge clk);
    check(crcOk, 1'b1, "R9 crcOk hold");
    check(sigOk, 1'b1, "R9 sigOk hold");

    // R7: extra bytes after end
    for (int i = 0; i < 12; i++) begin
      byteValid = 1'b1; byteData = 8'(i * 37); @(negedge clk);
      check(done, 1'b0, "R7 no done on extra byte");
    end
    byteValid = 1'b0;
    check(crcOk, 1'b1, "R7 crcOk unchanged");
    check(sigOk, 1'b1, "R7 sigOk unchanged");

    // R8: start clears flags
    pulseStart();
    check(crcOk, 1'b0, "R8 start clears crcOk");
    check(sigOk, 1'b0, "R8 start clears sigOk");
    check(done, 1'b0, "R8 start clears done");

    // R8: restart mid-page
    buildPage(8'h33);
    for (int i = 0; i < 100; i++) begin
      byteValid = 1'b1; byteData = 8'(i ^ 8'hC3); @(negedge clk);
    end
    byteValid = 1'b0;
    runPage(0, 1'b1, 1'b1, "R8 restart mid page");

    // R8: byte in start cycle not accepted
    buildPage(8'h21);
    start = 1'b1; byteValid = 1'b1; byteData = 8'h99;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 256; i++) begin
      byteData = page[i]; @(negedge clk);
    end
    byteValid = 1'b0;
    check(done, 1'b1, "R8 start cycle byte dropped done");
    check(crcOk, 1'b1, "R8 start cycle byte dropped crc");
    @(negedge clk);

    // R4: swapped check bytes
    buildPage(8'h10);
    if (page[254] == page[255]) page[3] = page[3];
    begin
      logic [7:0] t;
      t = page[254]; page[254] = page[255]; page[255] = t;
    end
    runPage(0, (page[254] == page[255]), 1'b1, "R4 swapped check bytes");

    // R5: each signature byte wrong, CRC resealed
    for (int k = 0; k < 4; k++) begin
      buildPage(8'h44);
      page[k] = page[k] ^ 8'h20;
      sealPage();
      runPage(0, 1'b1, 1'b0, "R5 bad signature");
    end

    // R3 R1: single-bit error sweep over covered bytes, check unchanged
    for (int p = 0; p < 254; p++) begin
      buildPage(8'h6C);
      page[p] = page[p] ^ (8'h01 << (p % 8));
      runPage(0, 1'b0, (p >= 4), "R3 single bit error");
    end

    // R4: error in check field high byte
    buildPage(8'h6C);
    page[255] = page[255] ^ 8'h80;
    runPage(0, 1'b0, 1'b1, "R4 check high byte error");

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testCnt++;
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule